// File: doc/BRIEF.md
# Burst-of-Two Quad-Data-Rate SRAM Command Sequencer

This block turns user read and write requests into the pin sequence of a synchronous SRAM that has separate read and write data ports, transfers data on both clock edges, and moves two words per access. It drives the active-low read strobe, the active-low write strobe, one active-low write mask bit per 9-bit lane, the shared address bus and the write data bus. It samples returned read data at a fixed latency and hands both words back to the user as one result.

The block runs on one internal clock at twice the memory clock rate, so each internal clock (a "tick") stands for one memory clock edge. Ticks alternate between rising-edge and falling-edge slots. A command always starts on a rising slot. In that slot the read address goes out with the read strobe, and the first write word goes out with the write strobe. In the falling slot that follows, the write address and the second write word go out. A read and a write can be accepted together, and each port can accept a new request on every rising slot.

Top module: `qdr_seq`

## Requirements
- R1: While `rst` is high, `mem_rd_n`, `mem_wr_n` and every bit of `mem_bw_n` are 1, and `rdata_valid` is 0.
- R2: `rd_ready` and `wr_ready` are always equal. After reset they are 0 on the first clock and then toggle on every clock, so a request is accepted only on clocks that precede a rising slot.
- R3: A read accepted on a clock edge drives `mem_rd_n` low for exactly the next clock, with `mem_addr` equal to the accepted `rd_addr` during that clock.
- R4: A write accepted on a clock edge drives, during the next clock, `mem_wr_n` low, `mem_d` = `wr_data[DW-1:0]` and `mem_bw_n` = ~`wr_be[NB-1:0]`. During the clock after that, it drives `mem_wr_n` high, `mem_addr` = `wr_addr`, `mem_d` = `wr_data[2*DW-1:DW]` and `mem_bw_n` = ~`wr_be[2*NB-1:NB]`.
- R5: Bit i of a write mask (active-low on `mem_bw_n`, active-high on `wr_be`) covers data bits 9i to 9i+8 of its word, and a masked lane leaves the stored lane unchanged. On every clock that carries no write data, all `mem_bw_n` bits are 1.
- R6: A read and a write accepted on the same edge are both issued. The read address occupies the rising slot and the write address occupies the falling slot.
- R7: On any clock not preceded by an accepted read (or write), `mem_rd_n` (or `mem_wr_n`) is 1.
- R8: With `rd_valid` held high, a read is issued in every rising slot, with no gap.
- R9: For a read issued in tick T, the first word is sampled from `mem_q` during tick T+RD_LAT_TICKS and the second word during the tick after that. `rdata_valid` is high for exactly one clock, RD_LAT_TICKS+2 clocks after the accepting edge, with the first word in `rdata[DW-1:0]`.
- R10: Read results are returned in the order the reads were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the memory clock rate |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request accepted on this edge if valid |
| rd_addr | input | AW | Read word-pair address |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request accepted on this edge if valid |
| wr_addr | input | AW | Write word-pair address |
| wr_data | input | 2*DW | Two write words, first word in the low half |
| wr_be | input | 2*NB | Lane enables, first word's lanes in the low half |
| rdata_valid | output | 1 | One-clock pulse marking a completed read |
| rdata | output | 2*DW | Two read words, first word in the low half |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_bw_n | output | NB | Active-low lane write masks |
| mem_addr | output | AW | Memory address bus |
| mem_d | output | DW | Memory write data bus |
| mem_q | input | DW | Memory read data bus |

## Verification
Three situations are hard to reach from the ports. The first is a read and a write accepted on the same edge. The second is two of them aimed at the same address, where the read must return the contents from before the write. The third is a write whose masks change only some lanes, followed by a read of that address. Random traffic rarely lines these up, so the stimulus includes a stretch with both ports held valid on a four-address window, and a stretch of uninterrupted reads. A bench-side memory model, driven only from the pins, answers each read at the stated latency. Its data is compared against a reference memory that the bench updates in acceptance order.

// File: rtl/qdr_pkg.sv
`timescale 1ns/1ps
package qdr_pkg;

    localparam int unsigned LANE_W = 9;

    typedef enum logic {
        SLOT_RISE = 1'b0,
        SLOT_FALL = 1'b1
    } slot_e;

    function automatic int unsigned lane_count(input int unsigned width);
        return (width + LANE_W - 1) / LANE_W;
    endfunction

    function automatic slot_e next_slot(input slot_e cur);
        return (cur == SLOT_RISE) ? SLOT_FALL : SLOT_RISE;
    endfunction

endpackage

// File: rtl/qdr_cmd_issue.sv
`timescale 1ns/1ps
module qdr_cmd_issue
    import qdr_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 18,
    parameter int unsigned NB = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_fire,
    input  logic [AW-1:0]   rd_addr,
    input  logic            wr_fire,
    input  logic [AW-1:0]   wr_addr,
    input  logic [2*DW-1:0] wr_data,
    input  logic [2*NB-1:0] wr_be,
    output logic            slot_open,
    output logic            mem_rd_n,
    output logic            mem_wr_n,
    output logic [NB-1:0]   mem_bw_n,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_d
);

    typedef struct packed {
        logic          live;
        logic [AW-1:0] addr;
        logic [DW-1:0] word;
        logic [NB-1:0] lanes;
    } tail_t;

    slot_e slot_q;
    tail_t tail_q;

    // Requests are taken in the falling slot so that they reach the pins
    // in the rising slot that follows.
    assign slot_open = (slot_q == SLOT_FALL);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= SLOT_RISE;
            tail_q   <= '0;
            mem_rd_n <= 1'b1;
            mem_wr_n <= 1'b1;
            mem_bw_n <= '1;
            mem_addr <= '0;
            mem_d    <= '0;
        end else begin
            slot_q   <= next_slot(slot_q);
            mem_rd_n <= 1'b1;
            mem_wr_n <= 1'b1;
            mem_bw_n <= '1;
            if (slot_q == SLOT_FALL) begin
                tail_q.live <= wr_fire;
                if (rd_fire) begin
                    mem_rd_n <= 1'b0;
                    mem_addr <= rd_addr;
                end
                if (wr_fire) begin
                    mem_wr_n     <= 1'b0;
                    mem_d        <= wr_data[DW-1:0];
                    mem_bw_n     <= ~wr_be[NB-1:0];
                    tail_q.addr  <= wr_addr;
                    tail_q.word  <= wr_data[2*DW-1:DW];
                    tail_q.lanes <= wr_be[2*NB-1:NB];
                end
            end else begin
                tail_q.live <= 1'b0;
                if (tail_q.live) begin
                    mem_addr <= tail_q.addr;
                    mem_d    <= tail_q.word;
                    mem_bw_n <= ~tail_q.lanes;
                end
            end
        end
    end

endmodule

// File: rtl/qdr_rd_capture.sv
`timescale 1ns/1ps
module qdr_rd_capture #(
    parameter int unsigned DW           = 18,
    parameter int unsigned RD_LAT_TICKS = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue,
    input  logic [DW-1:0]   mem_q,
    output logic            rdata_valid,
    output logic [2*DW-1:0] rdata
);

    localparam int unsigned DEPTH  = RD_LAT_TICKS + 2;
    localparam int unsigned TAP_LO = RD_LAT_TICKS;
    localparam int unsigned TAP_HI = RD_LAT_TICKS + 1;

    logic [DEPTH-1:0] age_q;
    logic [DW-1:0]    first_q;

    // age_q[k] is set during tick k after the read command tick.
    always_ff @(posedge clk) begin
        if (rst) begin
            age_q       <= '0;
            first_q     <= '0;
            rdata_valid <= 1'b0;
            rdata       <= '0;
        end else begin
            age_q       <= {age_q[DEPTH-2:0], issue};
            rdata_valid <= age_q[TAP_HI];
            if (age_q[TAP_LO]) first_q <= mem_q;
            if (age_q[TAP_HI]) rdata   <= {mem_q, first_q};
        end
    end

endmodule

// File: rtl/qdr_seq.sv
`timescale 1ns/1ps
module qdr_seq
    import qdr_pkg::*;
#(
    parameter int unsigned AW           = 8,
    parameter int unsigned DW           = 18,
    parameter int unsigned RD_LAT_TICKS = 5,
    localparam int unsigned NB          = lane_count(DW)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_valid,
    output logic            rd_ready,
    input  logic [AW-1:0]   rd_addr,
    input  logic            wr_valid,
    output logic            wr_ready,
    input  logic [AW-1:0]   wr_addr,
    input  logic [2*DW-1:0] wr_data,
    input  logic [2*NB-1:0] wr_be,
    output logic            rdata_valid,
    output logic [2*DW-1:0] rdata,
    output logic            mem_rd_n,
    output logic            mem_wr_n,
    output logic [NB-1:0]   mem_bw_n,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_d,
    input  logic [DW-1:0]   mem_q
);

    logic slot_open;
    logic rd_fire;
    logic wr_fire;

    assign rd_ready = slot_open;
    assign wr_ready = slot_open;
    assign rd_fire  = rd_valid && slot_open;
    assign wr_fire  = wr_valid && slot_open;

    qdr_cmd_issue #(.AW(AW), .DW(DW), .NB(NB)) u_issue (
        .clk       (clk),
        .rst       (rst),
        .rd_fire   (rd_fire),
        .rd_addr   (rd_addr),
        .wr_fire   (wr_fire),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_be     (wr_be),
        .slot_open (slot_open),
        .mem_rd_n  (mem_rd_n),
        .mem_wr_n  (mem_wr_n),
        .mem_bw_n  (mem_bw_n),
        .mem_addr  (mem_addr),
        .mem_d     (mem_d)
    );

    qdr_rd_capture #(.DW(DW), .RD_LAT_TICKS(RD_LAT_TICKS)) u_cap (
        .clk         (clk),
        .rst         (rst),
        .issue       (rd_fire),
        .mem_q       (mem_q),
        .rdata_valid (rdata_valid),
        .rdata       (rdata)
    );

endmodule

// File: rtl/qdr_seq_chk.sv
`timescale 1ns/1ps
module qdr_seq_chk #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 18,
    parameter int unsigned NB = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            rd_valid,
    input logic            rd_ready,
    input logic [AW-1:0]   rd_addr,
    input logic            wr_valid,
    input logic            wr_ready,
    input logic [AW-1:0]   wr_addr,
    input logic [2*DW-1:0] wr_data,
    input logic [2*NB-1:0] wr_be,
    input logic            rdata_valid,
    input logic            mem_rd_n,
    input logic            mem_wr_n,
    input logic [NB-1:0]   mem_bw_n,
    input logic [AW-1:0]   mem_addr,
    input logic [DW-1:0]   mem_d
);

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (rst)
        rd_ready |=> !rd_ready);
    a_r2_ready_rises: assert property (@(posedge clk) disable iff (rst)
        !rd_ready |=> rd_ready);
    a_r3_rd_issue: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready) |=> (!mem_rd_n && mem_addr == $past(rd_addr)));
    a_r3_rd_one_tick: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_n |=> mem_rd_n);
    a_r4_wr_head: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> (!mem_wr_n && mem_d == $past(wr_data[DW-1:0])
                                    && mem_bw_n == ~$past(wr_be[NB-1:0])));
    a_r4_wr_tail: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> ##1 (mem_wr_n && mem_addr == $past(wr_addr, 2)
                                        && mem_d == $past(wr_data[2*DW-1:DW], 2)));
    a_r5_masks_quiet: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_n && $past(mem_wr_n)) |-> (&mem_bw_n));
    a_r7_rd_idle: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && rd_ready) |=> mem_rd_n);
    a_r7_wr_idle: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid && wr_ready) |=> mem_wr_n);
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |=> !rdata_valid);

endmodule

bind qdr_seq qdr_seq_chk #(.AW(AW), .DW(DW), .NB(NB)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_addr     (rd_addr),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_be       (wr_be),
    .rdata_valid (rdata_valid),
    .mem_rd_n    (mem_rd_n),
    .mem_wr_n    (mem_wr_n),
    .mem_bw_n    (mem_bw_n),
    .mem_addr    (mem_addr),
    .mem_d       (mem_d)
);

// File: tb/sim_qdr_seq.sv
`timescale 1ns/1ps
module sim_qdr_seq;

    localparam int AW  = 8;
    localparam int DW  = 18;
    localparam int NB  = 2;
    localparam int LAT = 5;
    localparam int NT  = 3000;

    logic            clk = 1'b0;
    logic            rst;
    logic            rd_valid, wr_valid;
    logic            rd_ready, wr_ready;
    logic [AW-1:0]   rd_addr, wr_addr;
    logic [2*DW-1:0] wr_data;
    logic [2*NB-1:0] wr_be;
    logic            rdata_valid;
    logic [2*DW-1:0] rdata;
    logic            mem_rd_n, mem_wr_n;
    logic [NB-1:0]   mem_bw_n;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_d;
    logic [DW-1:0]   mem_q;

    always #2.5 clk = ~clk;

    qdr_seq #(.AW(AW), .DW(DW), .RD_LAT_TICKS(LAT)) u0 (
        .clk(clk), .rst(rst),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be),
        .rdata_valid(rdata_valid), .rdata(rdata),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_bw_n(mem_bw_n),
        .mem_addr(mem_addr), .mem_d(mem_d), .mem_q(mem_q)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [DW-1:0] pin_mem [0:(1<<AW)-1][0:1];
    logic [DW-1:0] ref_mem [0:(1<<AW)-1][0:1];
    logic [DW-1:0] sch_d   [0:15];
    logic          sch_v   [0:15];
    logic [2*DW-1:0] exp_data[$];
    int              exp_tick[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w,
                                                 input logic [NB-1:0] en);
        logic [DW-1:0] r;
        r = old_w;
        for (int i = 0; i < NB; i++)
            if (en[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
        return r;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit            p_rd, p_wr, p_wr2, prev_rdy, prev_vld, pm_wpend;
        logic [AW-1:0] p_rd_a, p_wr_a;
        logic [DW-1:0] p_w0, p_w1, pm_w0;
        logic [NB-1:0] p_be0, p_be1, pm_be0;
        int            seed;
        seed = $urandom(32'd4242);
        rst = 1'b1; rd_valid = 0; wr_valid = 0; rd_addr = '0; wr_addr = '0;
        wr_data = '0; wr_be = '0; mem_q = '0;
        for (int a = 0; a < (1 << AW); a++)
            for (int w = 0; w < 2; w++) begin
                pin_mem[a][w] = '0;
                ref_mem[a][w] = '0;
            end
        for (int i = 0; i < 16; i++) begin sch_v[i] = 0; sch_d[i] = '0; end
        p_rd = 0; p_wr = 0; p_wr2 = 0; prev_rdy = 0; prev_vld = 0; pm_wpend = 0;
        p_rd_a = '0; p_wr_a = '0; p_w0 = '0; p_w1 = '0; p_be0 = '0; p_be1 = '0;
        pm_w0 = '0; pm_be0 = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state of the pins
        chk(mem_rd_n && mem_wr_n, "R1 strobes in reset", {mem_rd_n, mem_wr_n}, 2'b11);
        chk(&mem_bw_n, "R1 masks in reset", mem_bw_n, '1);
        chk(!rdata_valid, "R1 rdata_valid in reset", rdata_valid, 0);
        rst = 1'b0;

        for (int t = 0; t < NT; t++) begin
            bit            rv, wv, acc_rd, acc_wr;
            logic [AW-1:0] ra, wa;
            logic [2*DW-1:0] wd;
            logic [2*NB-1:0] be;
            @(negedge clk);

            // pin checks for what was accepted on the last edge
            if (p_rd) begin
                chk(!mem_rd_n, p_wr ? "R6 read strobe with write" : "R3 read strobe",
                    mem_rd_n, 0);
                chk(mem_addr == p_rd_a, "R3 read address (R8 stream)", mem_addr, p_rd_a);
            end else
                chk(mem_rd_n, "R7 read strobe idle", mem_rd_n, 1);
            if (p_wr) begin
                chk(!mem_wr_n, "R4 write strobe", mem_wr_n, 0);
                chk(mem_d == p_w0, "R4 first write word", mem_d, p_w0);
                chk(mem_bw_n == ~p_be0, "R4 first masks", mem_bw_n, ~p_be0);
            end else
                chk(mem_wr_n, "R7 write strobe idle", mem_wr_n, 1);
            if (p_wr2) begin
                chk(mem_addr == p_wr_a, "R6 write address in falling slot", mem_addr, p_wr_a);
                chk(mem_d == p_w1, "R4 second write word", mem_d, p_w1);
                chk(mem_bw_n == ~p_be1, "R4 second masks", mem_bw_n, ~p_be1);
            end
            if (!p_wr && !p_wr2)
                chk(&mem_bw_n, "R5 masks idle", mem_bw_n, '1);
            p_wr2 = p_wr;

            // pin-level memory model
            if (!mem_wr_n) begin
                pm_w0 = mem_d; pm_be0 = ~mem_bw_n; pm_wpend = 1;
            end else if (pm_wpend) begin
                pin_mem[mem_addr][0] = lane_merge(pin_mem[mem_addr][0], pm_w0, pm_be0);
                pin_mem[mem_addr][1] = lane_merge(pin_mem[mem_addr][1], mem_d, ~mem_bw_n);
                pm_wpend = 0;
            end
            if (!mem_rd_n) begin
                sch_d[(t + LAT) % 16]     = pin_mem[mem_addr][0];
                sch_v[(t + LAT) % 16]     = 1;
                sch_d[(t + LAT + 1) % 16] = pin_mem[mem_addr][1];
                sch_v[(t + LAT + 1) % 16] = 1;
            end
            mem_q = sch_v[t % 16] ? sch_d[t % 16] : '0;
            sch_v[t % 16] = 0;

            // read results
            if (rdata_valid) begin
                chk(!prev_vld, "R9 single-clock valid", prev_vld, 0);
                if (exp_data.size() == 0)
                    chk(0, "R10 unexpected result", rdata, 0);
                else begin
                    logic [2*DW-1:0] ed;
                    int et;
                    ed = exp_data.pop_front();
                    et = exp_tick.pop_front();
                    chk(rdata == ed, "R9 R10 R5 read data", rdata, ed);
                    chk(t == et, "R9 result timing", t, et);
                end
            end
            prev_vld = rdata_valid;

            // R2: ready alternates
            chk(rd_ready == wr_ready, "R2 ready match", rd_ready, wr_ready);
            if (t > 0) chk(rd_ready != prev_rdy, "R2 ready toggles", rd_ready, !prev_rdy);
            prev_rdy = rd_ready;

            // stimulus
            rv = 0; wv = 0;
            ra = AW'($urandom_range(0, 15));
            wa = AW'($urandom_range(0, 15));
            wd = {18'($urandom), 18'($urandom)};
            be = 4'($urandom);
            if (t < 200) begin
                rv = $urandom_range(0, 1) == 1; wv = $urandom_range(0, 1) == 1;
            end else if (t < 400) begin
                rv = 1;                      // R8 uninterrupted reads
            end else if (t < 600) begin
                rv = 1; wv = 1;              // R6 both ports each slot
                ra = AW'($urandom_range(0, 3)); wa = ra;
            end else if (t < 700) begin
                rv = 0; wv = 0;              // R7 idle stretch
            end else if (t < 2900) begin
                rv = $urandom_range(0, 2) != 0; wv = $urandom_range(0, 2) != 0;
                if ($urandom_range(0, 3) == 0) be = 4'b0110;
            end
            rd_valid = rv; wr_valid = wv; rd_addr = ra; wr_addr = wa;
            wr_data = wd; wr_be = be;
            acc_rd = rv && rd_ready;
            acc_wr = wv && wr_ready;
            if (acc_rd) begin
                exp_data.push_back({ref_mem[ra][1], ref_mem[ra][0]});
                exp_tick.push_back(t + LAT + 3);
            end
            if (acc_wr) begin
                ref_mem[wa][0] = lane_merge(ref_mem[wa][0], wd[DW-1:0], be[NB-1:0]);
                ref_mem[wa][1] = lane_merge(ref_mem[wa][1], wd[2*DW-1:DW], be[2*NB-1:NB]);
            end
            p_rd = acc_rd; p_rd_a = ra;
            p_wr = acc_wr;
            if (acc_wr) begin
                p_wr_a = wa; p_w0 = wd[DW-1:0]; p_w1 = wd[2*DW-1:DW];
                p_be0 = be[NB-1:0]; p_be1 = be[2*NB-1:NB];
            end
        end
        chk(exp_data.size() == 0, "R10 all results returned", exp_data.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule